// File: doc/BRIEF.md
# Terminal Address Check and Command Field Decoder

This block sits behind the serial word decoder of a dual-redundant serial-bus remote terminal. Each time a validated 16-bit command word arrives, it decides whether the terminal answers the command as its own, takes it as a broadcast, or ignores it. For an accepted command it holds the subaddress, the transmit/receive bit and the word count on dedicated outputs until the next accepted command.

The terminal's own five-bit address comes from strap pins, together with a parity strap. The block checks that the six straps together have odd parity. If they do not, it raises an active-low error flag and stops answering single-terminal commands. Broadcast commands are still accepted in that case.

A five-bit address output shows either the latched word count or a running word counter that advances on each data strobe. The choice depends on whether the command is a mode command and on the in-command flag from the host side.

Top module: `rt_cmd_decoder`

## Requirements
- R1: `addr_err_n` is low exactly when the five address straps and the parity strap together hold an even number of ones.
- R2: While `addr_err_n` is low, a command whose address field equals the straps leaves `resp_o` low on the cycle after `cmd_vld`.
- R3: With `bcast_en` high, a command with address field 31 sets `bcast_o` and clears `resp_o` on the next cycle, whatever the strap parity.
- R4: With `bcast_en` low, a command with address field 31 sets neither `resp_o` nor `bcast_o`, even when the straps are 31.
- R5: With good strap parity, a command whose address field (bits 15:11) equals the straps and is not 31 sets `resp_o` high and `bcast_o` low on the next cycle.
- R6: A command that is neither answered nor broadcast clears `resp_o` and `bcast_o`. It leaves the latched fields and the word counter unchanged.
- R7: On an accepted command, `tr_o` takes bit 10, `sa_o` takes bits 9:5 and `cmd_wc_o` takes bits 4:0. These outputs hold until the next accepted command.
- R8: `mode_o` is high when the latched subaddress is all zeros or all ones. While it is high, `addr_lo_o` equals `cmd_wc_o` for either level of `in_cmd` and for any number of data strobes.
- R9: For a non-mode command with `in_cmd` high, `addr_lo_o` shows the word counter.
- R10: For a non-mode command with `in_cmd` low, `addr_lo_o` shows the received word count until the first data strobe. After that it shows the counter, which is the last count plus one.
- R11: The word counter clears to zero on each accepted command and increments once per `data_stb` while the latched command is non-mode.
- R12: `words_o` gives the number of data words of the latched command. A word count field of zero gives 32.
- R13: After reset, `resp_o`, `bcast_o`, `tr_o`, `sa_o`, `cmd_wc_o` and `addr_lo_o` are zero, `mode_o` is high and `words_o` is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 5 | Strapped terminal address |
| addr_par | input | 1 | Strapped parity bit (odd parity over straps) |
| bcast_en | input | 1 | Accept address 31 as broadcast |
| cmd_vld | input | 1 | One-cycle strobe: cmd_word holds a validated command |
| cmd_word | input | 16 | Received command word |
| in_cmd | input | 1 | Host-side in-command flag |
| data_stb | input | 1 | One-cycle strobe per data word transferred |
| resp_o | output | 1 | Command addressed to this terminal and accepted |
| bcast_o | output | 1 | Command accepted as broadcast |
| addr_err_n | output | 1 | Low on strap parity error |
| tr_o | output | 1 | Latched transmit/receive bit |
| sa_o | output | 5 | Latched subaddress field |
| mode_o | output | 1 | Latched command is a mode command |
| cmd_wc_o | output | 5 | Latched word count field |
| addr_lo_o | output | 5 | Word count or running counter, selected per R8 to R10 |
| words_o | output | 6 | Data word count, 1 to 32 |

## Verification
The accept decision is tried with straps of good and bad parity, broadcast enabled and disabled, a matching address, a foreign address, and address 31 under both a normal and an all-ones strap. Together these separate parity gating, broadcast handling and address matching, including the case where the strap equals 31 itself. Address-output selection is tried under a non-mode command and under a mode command, each with `in_cmd` at both levels and before and after data strobes. This separates the first-strobe word count, the live counter and the mode override. A rejected command sent between strobes shows that the counter and the latched fields survive it.

// File: rtl/rtcd_pkg.sv
package rtcd_pkg;
  function automatic logic sa_is_mode(input logic [4:0] sa);
    return (sa == 5'd0) || (sa == 5'h1f);
  endfunction
endpackage

// File: rtl/rtcd_addr_check.sv
module rtcd_addr_check #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] strap,
  input  logic          par,
  input  logic          bcast_en,
  input  logic [AW-1:0] field,
  output logic          hit_single,
  output logic          hit_bcast,
  output logic          err_n
);
  localparam logic [AW-1:0] BC_ADDR = '1;

  logic parity_ok;

  always_comb begin
    parity_ok  = ^{strap, par};
    err_n      = parity_ok;
    hit_bcast  = bcast_en && (field == BC_ADDR);
    hit_single = parity_ok && (field == strap) && (field != BC_ADDR);
  end
endmodule

// File: rtl/rtcd_field_reg.sv
module rtcd_field_reg #(
  parameter int SA_W = 5,
  parameter int WC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            tr_in,
  input  logic [SA_W-1:0] sa_in,
  input  logic [WC_W-1:0] wc_in,
  output logic            tr_q,
  output logic [SA_W-1:0] sa_q,
  output logic [WC_W-1:0] wc_q,
  output logic            mode_q
);
  logic            tr_d;
  logic [SA_W-1:0] sa_d;
  logic [WC_W-1:0] wc_d;

  always_comb begin
    tr_d = tr_q;
    sa_d = sa_q;
    wc_d = wc_q;
    if (load) begin
      tr_d = tr_in;
      sa_d = sa_in;
      wc_d = wc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_q <= 1'b0;
      sa_q <= '0;
      wc_q <= '0;
    end else begin
      tr_q <= tr_d;
      sa_q <= sa_d;
      wc_q <= wc_d;
    end
  end

  always_comb mode_q = (sa_q == '0) || (sa_q == '1);
endmodule

// File: rtl/rtcd_word_ctr.sv
module rtcd_word_ctr #(
  parameter int WC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            stb,
  input  logic            mode,
  input  logic            in_cmd,
  input  logic [WC_W-1:0] wc_lat,
  output logic [WC_W-1:0] addr_lo,
  output logic [WC_W:0]   words
);
  localparam logic [WC_W:0] FULL = {1'b1, {WC_W{1'b0}}};

  logic [WC_W-1:0] cnt_q, cnt_d;
  logic            first_q, first_d;

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    if (clr) begin
      cnt_d   = '0;
      first_d = 1'b1;
    end else if (stb) begin
      first_d = 1'b0;
      if (!mode) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  always_comb begin
    if (mode)        addr_lo = wc_lat;
    else if (in_cmd) addr_lo = cnt_q;
    else if (first_q) addr_lo = wc_lat;
    else             addr_lo = cnt_q;
    words = (wc_lat == '0) ? FULL : {1'b0, wc_lat};
  end
endmodule

// File: rtl/rt_cmd_decoder.sv
module rt_cmd_decoder #(
  parameter int AW   = 5,
  parameter int SA_W = 5,
  parameter int WC_W = 5,
  localparam int CW  = AW + 1 + SA_W + WC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_strap,
  input  logic            addr_par,
  input  logic            bcast_en,
  input  logic            cmd_vld,
  input  logic [CW-1:0]   cmd_word,
  input  logic            in_cmd,
  input  logic            data_stb,
  output logic            resp_o,
  output logic            bcast_o,
  output logic            addr_err_n,
  output logic            tr_o,
  output logic [SA_W-1:0] sa_o,
  output logic            mode_o,
  output logic [WC_W-1:0] cmd_wc_o,
  output logic [WC_W-1:0] addr_lo_o,
  output logic [WC_W:0]   words_o
);
  localparam int TR_POS = WC_W + SA_W;

  logic hit_single, hit_bcast, accept;
  logic resp_d, bcast_d;

  rtcd_addr_check #(.AW(AW)) u_adr (
    .strap      (addr_strap),
    .par        (addr_par),
    .bcast_en   (bcast_en),
    .field      (cmd_word[CW-1 -: AW]),
    .hit_single (hit_single),
    .hit_bcast  (hit_bcast),
    .err_n      (addr_err_n)
  );

  always_comb begin
    accept  = cmd_vld && (hit_single || hit_bcast);
    resp_d  = resp_o;
    bcast_d = bcast_o;
    if (cmd_vld) begin
      resp_d  = hit_single;
      bcast_d = hit_bcast;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_o  <= 1'b0;
      bcast_o <= 1'b0;
    end else begin
      resp_o  <= resp_d;
      bcast_o <= bcast_d;
    end
  end

  rtcd_field_reg #(.SA_W(SA_W), .WC_W(WC_W)) u_fld (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .tr_in  (cmd_word[TR_POS]),
    .sa_in  (cmd_word[TR_POS-1 -: SA_W]),
    .wc_in  (cmd_word[WC_W-1:0]),
    .tr_q   (tr_o),
    .sa_q   (sa_o),
    .wc_q   (cmd_wc_o),
    .mode_q (mode_o)
  );

  rtcd_word_ctr #(.WC_W(WC_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .stb     (data_stb && !cmd_vld),
    .mode    (mode_o),
    .in_cmd  (in_cmd),
    .wc_lat  (cmd_wc_o),
    .addr_lo (addr_lo_o),
    .words   (words_o)
  );
endmodule

// File: rtl/rtcd_chk.sv
module rtcd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  addr_strap,
  input logic        bcast_en,
  input logic        cmd_vld,
  input logic [15:0] cmd_word,
  input logic        resp_o,
  input logic        bcast_o,
  input logic        addr_err_n,
  input logic        tr_o,
  input logic [4:0]  sa_o,
  input logic        mode_o,
  input logic [4:0]  cmd_wc_o,
  input logic [4:0]  addr_lo_o
);
  logic is31, own, taken;
  always_comb begin
    is31  = cmd_word[15:11] == 5'h1f;
    own   = cmd_word[15:11] == addr_strap;
    taken = (addr_err_n && own && !is31) || (bcast_en && is31);
  end

  assert_parity_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && !addr_err_n |=> !resp_o);
  assert_bcast_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && is31 && bcast_en |=> bcast_o && !resp_o);
  assert_bcast_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && is31 && !bcast_en |=> !bcast_o && !resp_o);
  assert_own_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && addr_err_n && own && !is31 |=> resp_o && !bcast_o);
  assert_ignored_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && !taken |=> $stable(sa_o) && $stable(tr_o) && $stable(cmd_wc_o) && !resp_o && !bcast_o);
  assert_field_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && taken |=> sa_o == $past(cmd_word[9:5]) && tr_o == $past(cmd_word[10])
                         && cmd_wc_o == $past(cmd_word[4:0]));
  assert_mode_wc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o |-> addr_lo_o == cmd_wc_o);
endmodule

bind rt_cmd_decoder rtcd_chk u_rtcd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_strap (addr_strap),
  .bcast_en   (bcast_en),
  .cmd_vld    (cmd_vld),
  .cmd_word   (cmd_word),
  .resp_o     (resp_o),
  .bcast_o    (bcast_o),
  .addr_err_n (addr_err_n),
  .tr_o       (tr_o),
  .sa_o       (sa_o),
  .mode_o     (mode_o),
  .cmd_wc_o   (cmd_wc_o),
  .addr_lo_o  (addr_lo_o)
);

// File: tb/rt_cmd_decoder_bench.sv
module rt_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  addr_strap;
  logic        addr_par, bcast_en, cmd_vld, in_cmd, data_stb;
  logic [15:0] cmd_word;
  logic        resp_o, bcast_o, addr_err_n, tr_o, mode_o;
  logic [4:0]  sa_o, cmd_wc_o, addr_lo_o;
  logic [5:0]  words_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rt_cmd_decoder u_rt_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .addr_par(addr_par),
    .bcast_en(bcast_en), .cmd_vld(cmd_vld), .cmd_word(cmd_word), .in_cmd(in_cmd),
    .data_stb(data_stb), .resp_o(resp_o), .bcast_o(bcast_o), .addr_err_n(addr_err_n),
    .tr_o(tr_o), .sa_o(sa_o), .mode_o(mode_o), .cmd_wc_o(cmd_wc_o),
    .addr_lo_o(addr_lo_o), .words_o(words_o)
  );

  // entry: strap[25:21] par[20] bcast_en[19] word[18:3] resp[2] bcast[1] err_n[0]
  localparam logic [0:9][25:0] VEC = '{
    {5'd5,  1'b1, 1'b1, 5'd5,  1'b0, 5'd3,  5'd4,  1'b1, 1'b0, 1'b1},
    {5'd5,  1'b0, 1'b1, 5'd5,  1'b0, 5'd7,  5'd1,  1'b0, 1'b0, 1'b0},
    {5'd5,  1'b0, 1'b1, 5'd31, 1'b0, 5'd2,  5'd7,  1'b0, 1'b1, 1'b0},
    {5'd5,  1'b1, 1'b0, 5'd31, 1'b1, 5'd2,  5'd7,  1'b0, 1'b0, 1'b1},
    {5'd5,  1'b1, 1'b1, 5'd6,  1'b0, 5'd9,  5'd2,  1'b0, 1'b0, 1'b1},
    {5'd31, 1'b0, 1'b0, 5'd31, 1'b0, 5'd4,  5'd3,  1'b0, 1'b0, 1'b1},
    {5'd31, 1'b0, 1'b1, 5'd31, 1'b1, 5'd4,  5'd3,  1'b0, 1'b1, 1'b1},
    {5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 5'd31, 5'd0,  1'b1, 1'b0, 1'b1},
    {5'd0,  1'b0, 1'b1, 5'd0,  1'b0, 5'd8,  5'd8,  1'b0, 1'b0, 1'b0},
    {5'd10, 1'b1, 1'b1, 5'd10, 1'b1, 5'd0,  5'd17, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_word = w;
    cmd_vld  = 1'b1;
    @(negedge clk);
    cmd_vld  = 1'b0;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      data_stb = 1'b1;
      @(negedge clk);
      data_stb = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic       last_tr;
    logic [4:0] last_sa, last_wc;
    rst_n = 1'b0; addr_strap = 5'd5; addr_par = 1'b1; bcast_en = 1'b1;
    cmd_vld = 1'b0; cmd_word = '0; in_cmd = 1'b0; data_stb = 1'b0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 resp", resp_o, 0);   chk("R13 bcast", bcast_o, 0);
    chk("R13 sa", sa_o, 0);       chk("R13 tr", tr_o, 0);
    chk("R13 mode", mode_o, 1);   chk("R13 addr_lo", addr_lo_o, 0);
    chk("R13 words", words_o, 32);
    @(negedge clk);
    rst_n = 1'b1;
    last_tr = 1'b0; last_sa = '0; last_wc = '0;

    for (int k = 0; k < 10; k++) begin
      addr_strap = VEC[k][25:21];
      addr_par   = VEC[k][20];
      bcast_en   = VEC[k][19];
      send(VEC[k][18:3]);
      chk("R1 err_n", addr_err_n, VEC[k][0]);
      chk("R2/R5 resp", resp_o, VEC[k][2]);
      chk("R3/R4 bcast", bcast_o, VEC[k][1]);
      if (VEC[k][2] || VEC[k][1]) begin
        last_tr = VEC[k][13]; last_sa = VEC[k][12:8]; last_wc = VEC[k][7:3];
      end
      chk("R6/R7 sa", sa_o, last_sa);
      chk("R6/R7 tr", tr_o, last_tr);
      chk("R6/R7 wc", cmd_wc_o, last_wc);
    end

    // non-mode command: sa 3, wc 4
    addr_strap = 5'd5; addr_par = 1'b1; bcast_en = 1'b1; in_cmd = 1'b0;
    send({5'd5, 1'b0, 5'd3, 5'd4});
    chk("R10 first wc", addr_lo_o, 4);
    chk("R8 mode flag", mode_o, 0);
    chk("R12 words", words_o, 4);
    in_cmd = 1'b1; #1;
    chk("R9 counter zero", addr_lo_o, 0);
    strobe(3);
    chk("R11 counter 3", addr_lo_o, 3);
    in_cmd = 1'b0; #1;
    chk("R10 after strobe", addr_lo_o, 3);
    // R6 ignored command keeps counter and fields
    send({5'd9, 1'b1, 5'd12, 5'd20});
    in_cmd = 1'b1; #1;
    chk("R6 counter kept", addr_lo_o, 3);
    chk("R6 sa kept", sa_o, 3);
    // R11 new accepted command clears counter
    send({5'd5, 1'b1, 5'd6, 5'd0});
    chk("R11 cleared", addr_lo_o, 0);
    chk("R12 zero is 32", words_o, 32);
    in_cmd = 1'b0; #1;
    chk("R10 first wc zero", addr_lo_o, 0);
    strobe(1);
    chk("R10 last plus one", addr_lo_o, 1);

    // mode command: sa 31, wc 9
    send({5'd5, 1'b1, 5'd31, 5'd9});
    chk("R8 mode flag", mode_o, 1);
    in_cmd = 1'b1; #1;
    chk("R8 in_cmd high", addr_lo_o, 9);
    strobe(2);
    chk("R8 after strobes", addr_lo_o, 9);
    in_cmd = 1'b0; #1;
    chk("R8 in_cmd low", addr_lo_o, 9);
    // mode subaddress zero
    send({5'd5, 1'b0, 5'd0, 5'd2});
    in_cmd = 1'b1; #1;
    chk("R8 sa zero", addr_lo_o, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule